// File: doc/BRIEF.md
# Asynchronous Handshake Bus Target

This block is the responding side of a parallel bus whose transfers are closed by a strobe/acknowledge handshake rather than by a fixed number of clocks. The master places an address, an address-modifier code and a read/write direction on the bus, then raises the address and data strobes. The target brings both strobes into its local clock domain and checks whether the upper address bits fall inside its window. If they do, it answers the transfer. A valid write is stored in a small local register file and acknowledged. A valid read puts register contents on the bus and enables the output, and only then acknowledges.

An access that hits the window but uses an address-modifier code the target does not accept, or an offset with no register behind it, receives a bus error instead of an acknowledge. Whichever response is given stays asserted for as long as the master holds the data strobe. The target withdraws it once the strobe falls, so every transfer goes through all four handshake phases. Addresses outside the window get no response at all.

Top module: `abus_target`

## Requirements
- R1: After reset, ack_o, berr_o and rdata_oe_o are low and every register reads back as zero.
- R2: Only an address whose upper ADDR_W-OFF_W bits equal BASE (default 0x14, so addresses 0xA0 to 0xA7) selects the target. Any other address produces no ack_o, no berr_o and no rdata_oe_o.
- R3: A write (wr_i=1) inside the window to an offset below NUM_REGS (default 6), with an accepted modifier code (default 0x39 or 0x3D), stores wdata_i in that register and raises ack_o.
- R4: On an accepted read (wr_i=0), rdata_o carries the addressed register and rdata_oe_o is high one cycle before ack_o rises. Both stay that way while ack_o is high.
- R5: An access inside the window with any other modifier code raises berr_o and not ack_o. A write of this kind leaves the register file unchanged.
- R6: An access to offset NUM_REGS or above inside the window raises berr_o and not ack_o.
- R7: ack_o or berr_o stays asserted while the data strobe is held, and is released within three clock cycles after ds_i falls.
- R8: rdata_oe_o is high only during an accepted read while the strobes are held. It is never high for a write, a bus error or an unselected access.
- R9: ack_o and berr_o are never high in the same cycle.
- R10: as_i and ds_i pass through a two-stage synchronizer. A write acknowledge or bus error appears on the third rising clock edge after the strobes rise, and a read acknowledge on the fourth. No response appears earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Bus address |
| am_i | input | AM_W | Address-modifier code |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| as_i | input | 1 | Address strobe, active high, asynchronous |
| ds_i | input | 1 | Data strobe, active high, asynchronous |
| wdata_i | input | DATA_W | Write data from master |
| rdata_o | output | DATA_W | Read data toward master |
| rdata_oe_o | output | 1 | Read data output enable |
| ack_o | output | 1 | Transfer acknowledge |
| berr_o | output | 1 | Bus error |

## Verification
The bench sweeps every offset of the window under both accepted modifier codes and one rejected code, first writing and then reading. A target that let a rejected write reach the register file would return the wrong value on the later read. Mapping the two spare offsets wrongly would show up as an acknowledge where a bus error is expected. After each response appears, the bench holds the strobes for a few extra cycles and then counts the cycles until the response is released. A target that pulsed its acknowledge would fail the hold check, and one that ignored the strobe falling would fail the release check. The bench also checks the exact edge on which each response and the output enable appear, so a read that acknowledged before its data was on the bus, or a synchronizer of the wrong depth, would be reported. Accesses outside the window must leave all three outputs quiet.

// File: rtl/abus_pkg.sv
`timescale 1ns/1ps
package abus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RDRV,
    ST_ACK,
    ST_ERR
  } abus_state_e;
endpackage

// File: rtl/abus_sync.sv
`timescale 1ns/1ps
module abus_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/abus_decode.sv
`timescale 1ns/1ps
module abus_decode #(
  parameter int ADDR_W   = 8,
  parameter int OFF_W    = 3,
  parameter int AM_W     = 6,
  parameter int NUM_REGS = 6,
  parameter int NUM_AM   = 2,
  parameter logic [ADDR_W-OFF_W-1:0] BASE = '0,
  parameter logic [NUM_AM-1:0][AM_W-1:0] AM_LIST = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [AM_W-1:0]   am_i,
  output logic              hit_o,
  output logic              ok_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [NUM_AM-1:0] am_match;

  for (genvar g = 0; g < NUM_AM; g++) begin : g_am
    assign am_match[g] = (am_i == AM_LIST[g]);
  end

  assign off_o = addr_i[OFF_W-1:0];
  assign hit_o = (addr_i[ADDR_W-1:OFF_W] == BASE);
  // both conditions are needed for a normal completion
  assign ok_o  = (|am_match) && (32'(off_o) < NUM_REGS);
endmodule

// File: rtl/abus_regfile.sv
`timescale 1ns/1ps
module abus_regfile #(
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 3,
  parameter int NUM_REGS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && (idx_i == OFF_W'(g)))     regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx_i == OFF_W'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/abus_target.sv
`timescale 1ns/1ps
module abus_target #(
  parameter int ADDR_W   = 8,
  parameter int OFF_W    = 3,
  parameter int AM_W     = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 6,
  parameter int NUM_AM   = 2,
  parameter logic [ADDR_W-OFF_W-1:0] BASE = 5'h14,
  parameter logic [NUM_AM-1:0][AM_W-1:0] AM_LIST = {6'h3D, 6'h39}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [AM_W-1:0]   am_i,
  input  logic              wr_i,
  input  logic              as_i,
  input  logic              ds_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              ack_o,
  output logic              berr_o
);
  import abus_pkg::*;

  logic              as_s, ds_s;
  logic              hit, ok;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] rf_rdata;
  logic              start, we;

  abus_state_e       st_q;
  logic              ack_q, berr_q, rd_q;
  logic [DATA_W-1:0] rdata_q;

  abus_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({as_i, ds_i}),
    .q_o   ({as_s, ds_s})
  );

  abus_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .AM_W(AM_W), .NUM_REGS(NUM_REGS),
    .NUM_AM(NUM_AM), .BASE(BASE), .AM_LIST(AM_LIST)
  ) u_dec (
    .addr_i(addr_i),
    .am_i  (am_i),
    .hit_o (hit),
    .ok_o  (ok),
    .off_o (off)
  );

  assign start = (st_q == ST_IDLE) && as_s && ds_s && hit;
  assign we    = start && ok && wr_i;

  abus_regfile #(
    .DATA_W(DATA_W), .OFF_W(OFF_W), .NUM_REGS(NUM_REGS)
  ) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .idx_i  (off),
    .wdata_i(wdata_i),
    .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ack_q   <= 1'b0;
      berr_q  <= 1'b0;
      rd_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (!ok) begin
            st_q   <= ST_ERR;
            berr_q <= 1'b1;
          end else if (wr_i) begin
            st_q  <= ST_ACK;
            ack_q <= 1'b1;
          end else begin
            st_q    <= ST_RDRV;
            rd_q    <= 1'b1;
            rdata_q <= rf_rdata;
          end
        end
        // one cycle of data on the bus before acknowledging
        ST_RDRV: begin
          st_q  <= ST_ACK;
          ack_q <= 1'b1;
        end
        ST_ACK: if (!ds_s) begin
          st_q  <= ST_IDLE;
          ack_q <= 1'b0;
          rd_q  <= 1'b0;
        end
        ST_ERR: if (!ds_s) begin
          st_q   <= ST_IDLE;
          berr_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rdata_o    = rdata_q;
  assign rdata_oe_o = rd_q && as_s && ds_s;
  assign ack_o      = ack_q;
  assign berr_o     = berr_q;
endmodule

// File: rtl/abus_target_chk.sv
`timescale 1ns/1ps
module abus_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic ds_s,
  input logic ack_o,
  input logic berr_o,
  input logic rdata_oe_o
);
  AST_RESP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && berr_o)); // R9

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && ds_s |=> ack_o); // R7

  AST_BERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o && ds_s |=> berr_o); // R7

  AST_RESP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || berr_o) && !ds_s |=> !ack_o && !berr_o); // R7

  AST_RD_DATA_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) && !wr_i |-> $past(rdata_oe_o) && rdata_oe_o); // R4

  AST_OE_NOT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> !berr_o && !wr_i); // R8
endmodule

bind abus_target abus_target_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .ds_s      (ds_s),
  .ack_o     (ack_o),
  .berr_o    (berr_o),
  .rdata_oe_o(rdata_oe_o)
);

// File: tb/sim_abus_target.sv
`timescale 1ns/1ps
module sim_abus_target;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [5:0]  am_i = '0;
  logic        wr_i = 1'b0;
  logic        as_i = 1'b0;
  logic        ds_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        rdata_oe_o, ack_o, berr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [5:0] AM_TAB [3] = '{6'h39, 6'h3D, 6'h2F};
  localparam int K_NONE = 0, K_WACK = 1, K_RACK = 2, K_ERR = 3;

  logic [15:0] shadow [6];

  always #5 clk = ~clk;

  abus_target u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .am_i(am_i), .wr_i(wr_i),
    .as_i(as_i), .ds_i(ds_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .ack_o(ack_o), .berr_o(berr_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {ack_o, berr_o, rdata_oe_o};
  endfunction

  task automatic xfer(input logic [7:0] a, input logic [5:0] am, input bit wr,
                      input logic [15:0] wd, input int kind, input logic [15:0] exp_rd,
                      input string rq);
    logic [2:0] hold;
    @(negedge clk);
    addr_i = a; am_i = am; wr_i = wr; wdata_i = wd; as_i = 1'b1; ds_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(outs() == 3'b000, "R10", 32'(outs()), 0);
    @(negedge clk);
    case (kind)
      K_WACK: chk(outs() == 3'b100, "R3", 32'(outs()), 32'b100);
      K_RACK: begin
        chk(outs() == 3'b001, "R4", 32'(outs()), 32'b001);
        chk(rdata_o == exp_rd, rq, 32'(rdata_o), 32'(exp_rd));
      end
      K_ERR:  chk(outs() == 3'b010, rq, 32'(outs()), 32'b010);
      default: chk(outs() == 3'b000, "R2", 32'(outs()), 0);
    endcase
    if (kind == K_RACK) begin
      @(negedge clk);
      chk(outs() == 3'b101 && rdata_o == exp_rd, "R4", {13'b0, outs(), rdata_o},
          {13'b0, 3'b101, exp_rd});
    end
    hold = (kind == K_WACK) ? 3'b100 : (kind == K_RACK) ? 3'b101 :
           (kind == K_ERR) ? 3'b010 : 3'b000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(outs() == hold, "R7", 32'(outs()), 32'(hold));
      chk(!(ack_o && berr_o), "R9", 32'(outs()), 32'(hold));
    end
    as_i = 1'b0; ds_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(outs() == 3'b000, "R7", 32'(outs()), 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(outs() == 3'b000, "R1", 32'(outs()), 0);
    for (int o = 0; o < 6; o++)
      xfer(8'hA0 + 8'(o), 6'h39, 1'b0, '0, K_RACK, 16'h0, "R1");

    // write sweep: offsets x modifier codes
    for (int m = 0; m < 3; m++)
      for (int o = 0; o < 8; o++) begin
        logic [15:0] wd;
        wd = 16'h1000 * 16'(m + 1) + 16'h0101 * 16'(o) + 16'h005A;
        if (m < 2 && o < 6) begin
          xfer(8'hA0 + 8'(o), AM_TAB[m], 1'b1, wd, K_WACK, '0, "R3");
          shadow[o] = wd;
        end else
          xfer(8'hA0 + 8'(o), AM_TAB[m], 1'b1, wd, K_ERR, '0, (o >= 6) ? "R6" : "R5");
      end

    // read sweep: rejected writes must not have changed anything
    for (int m = 0; m < 3; m++)
      for (int o = 0; o < 8; o++) begin
        if (m < 2 && o < 6)
          xfer(8'hA0 + 8'(o), AM_TAB[m], 1'b0, '0, K_RACK, shadow[o], (m == 1) ? "R5" : "R3");
        else
          xfer(8'hA0 + 8'(o), AM_TAB[m], 1'b0, '0, K_ERR, '0, (o >= 6) ? "R6" : "R8");
      end

    // outside the window: silent
    xfer(8'hA8, 6'h39, 1'b1, 16'hDEAD, K_NONE, '0, "R2");
    xfer(8'h9F, 6'h39, 1'b0, '0, K_NONE, '0, "R2");
    xfer(8'h20, 6'h3D, 1'b1, 16'hBEEF, K_NONE, '0, "R2");
    xfer(8'h20, 6'h2F, 1'b0, '0, K_NONE, '0, "R8");
    // the out-of-window write to an alias of offset 0 must not land
    xfer(8'hA0, 6'h39, 1'b0, '0, K_RACK, shadow[0], "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule